// File: doc/BRIEF.md
# Sixteen-Pin Bidirectional I/O Port with Single-Write Bit Operations

This block is a 16-pin general-purpose I/O port that sits on a simple single-master memory-mapped bus. Each pin has its own direction bit. A pin whose direction bit is 1 is driven from an output latch. A pin whose direction bit is 0 is sampled through a two-flop synchronizer, and firmware reads the result as a level word.

Firmware can change selected output bits with a single bus write, with no read-modify-write sequence. Three write-only words each take a bit mask: one sets the latch bits named by the mask, one clears them and one inverts them. Every bus access, read or write, is answered with an acknowledge pulse that lasts one cycle and comes on the cycle after the strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction word and the output latch are all zeros. Every output enable is therefore low and every pin output is low.
- R2: A write to offset 0 loads the direction word. A 1 makes a pin an output, so its `pad_oe` bit is high. A 0 makes the pin an input. Reading offset 0 returns the direction word.
- R3: A write to offset 2 loads the output latch, and reading offset 2 returns the latch. `pad_out` always equals the latch ANDed with the direction word, so a pin set as an input drives low.
- R4: A write to offset 3 sets to 1 each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R5: A write to offset 4 clears to 0 each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R6: A write to offset 5 inverts each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R7: Reading offset 1 returns the pin levels after a two-flop synchronizer. A change on `pad_in` becomes visible in the read data two clocks after it is captured. Writes to offset 1 are ignored.
- R8: Offsets 3, 4 and 5 read as zero. Offsets 6 to 15 read as zero and ignore writes.
- R9: `bus_ack` is high for exactly one cycle, on the cycle after each strobe. `bus_rdata` is valid in that same cycle and is zero when `bus_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Local word offset |
| bus_wdata | input | 16 | Write data |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_rdata | output | 16 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Access acknowledge |
| pad_in | input | 16 | Pin input levels |
| pad_out | output | 16 | Pin output levels |
| pad_oe | output | 16 | Per-pin output enable |

## Verification
A wrong bit in the direction word or the output latch appears on `pad_oe` or `pad_out` on the very next cycle. It also appears in the read data of the next access to offset 0 or offset 2, so a fault in a set, clear or invert mask shows up at the pins one cycle after the write. A synchronizer that is too short or too long moves the input read data by one clock relative to a pin change, and the bench detects this by sampling at a fixed distance from the change. A misdecoded offset shows up either as a nonzero read from a write-only or unused offset, or as a latch change after a write that should have had no effect.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  parameter int unsigned PORT_W = 16;
  parameter int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR = 4'd0,
    OFS_LVL = 4'd1,
    OFS_LAT = 4'd2,
    OFS_SET = 4'd3,
    OFS_CLR = 4'd4,
    OFS_INV = 4'd5
  } ofs_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_INV  = 2'd3
  } lat_op_e;

  function automatic logic [PORT_W-1:0] lat_next(
    input logic [PORT_W-1:0] cur,
    input logic [PORT_W-1:0] d,
    input lat_op_e op);
    case (op)
      OP_SET:  lat_next = cur | d;
      OP_CLR:  lat_next = cur & ~d;
      OP_INV:  lat_next = cur ^ d;
      default: lat_next = d;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 2) && $past(rst_n) |=> q == $past(stg[0]));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         lat_we,
  input  lat_op_e      lat_op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      lat_q <= '0;
    else if (lat_we) lat_q <= lat_next(lat_q, wdata, lat_op);

  p_set_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we && lat_op == OP_SET |=> (lat_q & $past(wdata)) == $past(wdata)
      && ((lat_q ^ $past(lat_q)) & ~$past(wdata)) == '0);
  p_clr_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we && lat_op == OP_CLR |=> (lat_q & $past(wdata)) == '0
      && ((lat_q ^ $past(lat_q)) & ~$past(wdata)) == '0);
  p_inv_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we && lat_op == OP_INV |=> (lat_q ^ $past(lat_q)) == $past(wdata));
  p_lat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_we |=> $stable(lat_q));
endmodule

// File: rtl/gpio_bus_if.sv
module gpio_bus_if
  import gpio_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          stb,
  input  logic          we,
  input  logic [W-1:0]  dir_q,
  input  logic [W-1:0]  lat_q,
  input  logic [W-1:0]  lvl_q,
  output logic          dir_we,
  output logic          lat_we,
  output lat_op_e       lat_op,
  output logic [W-1:0]  rdata,
  output logic          ack
);
  logic          wr_hit;
  logic [W-1:0]  rd_mux;

  assign wr_hit = stb && we;

  always_comb begin
    dir_we = 1'b0;
    lat_we = 1'b0;
    lat_op = OP_LOAD;
    if (wr_hit) begin
      case (addr)
        OFS_DIR: dir_we = 1'b1;
        OFS_LAT: begin lat_we = 1'b1; lat_op = OP_LOAD; end
        OFS_SET: begin lat_we = 1'b1; lat_op = OP_SET;  end
        OFS_CLR: begin lat_we = 1'b1; lat_op = OP_CLR;  end
        OFS_INV: begin lat_we = 1'b1; lat_op = OP_INV;  end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_DIR: rd_mux = dir_q;
      OFS_LVL: rd_mux = lvl_q;
      OFS_LAT: rd_mux = lat_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= stb;
      rdata <= (stb && !we) ? rd_mux : '0;
    end

  p_ack_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> ack);
  p_ack_only_after_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !ack);
  p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> rdata == '0);
  p_wo_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb && !we && addr > OFS_LAT |=> rdata == '0);
  p_one_strobe_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dir_we, lat_we}));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W       = PORT_W,
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_stb,
  input  logic          bus_we,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_ack,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe
);
  logic [W-1:0] dir_q, lat_q, lvl_q;
  logic         dir_we, lat_we;
  lat_op_e      lat_op;

  gpio_sync #(.W(W), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_q));

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .lat_we(lat_we),
    .lat_op(lat_op), .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q));

  gpio_bus_if #(.W(W), .AW(AW)) u_bus (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .stb(bus_stb), .we(bus_we),
    .dir_q(dir_q), .lat_q(lat_q), .lvl_q(lvl_q), .dir_we(dir_we),
    .lat_we(lat_we), .lat_op(lat_op), .rdata(bus_rdata), .ack(bus_ack));

  assign pad_oe  = dir_q;
  assign pad_out = lat_q & dir_q;

  p_input_pin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && bus_we && bus_addr == OFS_DIR |=> pad_oe == $past(bus_wdata));
  p_unused_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && bus_we && bus_addr > OFS_INV |=> $stable(pad_oe) && $stable(pad_out));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_stb = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_lat, m_dir;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  gpio_port u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  // vector: addr (write), data
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, 16'hA5A5}, {4'd3, 16'h0F0F}, {4'd4, 16'h00FF},
    {4'd5, 16'hFFFF}, {4'd5, 16'h8001}, {4'd3, 16'h0000},
    {4'd4, 16'hF000}, {4'd2, 16'h1234}, {4'd5, 16'h0F00},
    {4'd3, 16'h8000}};

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on negedge; the ack and rdata are registered at the next posedge
  task automatic access(input logic we, input logic [3:0] a, input logic [15:0] d,
                        output logic [15:0] r);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
    check("R9 ack", {15'd0, bus_ack}, 16'd1);
    r = bus_rdata;
    @(negedge clk);
    check("R9 ack single", {15'd0, bus_ack}, 16'd0);
  endtask

  function automatic logic [15:0] model(input logic [3:0] a, input logic [15:0] cur,
                                        input logic [15:0] d);
    if (a == 4'd2) return d;
    if (a == 4'd3) return cur | d;
    if (a == 4'd4) return cur & ~d;
    if (a == 4'd5) return cur ^ d;
    return cur;
  endfunction

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe reset", pad_oe, 16'h0);
    check("R1 out reset", pad_out, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b1, 4'd0, 16'hFFFF, rd);
    m_dir = 16'hFFFF;
    check("R2 oe", pad_oe, 16'hFFFF);
    m_lat = '0;
    for (int i = 0; i < NV; i++) begin
      access(1'b1, VEC[i][19:16], VEC[i][15:0], rd);
      m_lat = model(VEC[i][19:16], m_lat, VEC[i][15:0]);
      case (VEC[i][19:16])
        4'd3: check("R4 set", pad_out, m_lat);
        4'd4: check("R5 clear", pad_out, m_lat);
        4'd5: check("R6 invert", pad_out, m_lat);
        default: check("R3 load", pad_out, m_lat);
      endcase
      access(1'b0, 4'd2, '0, rd);
      check("R3 latch read", rd, m_lat);
    end
    access(1'b1, 4'd0, 16'h00F0, rd);
    m_dir = 16'h00F0;
    access(1'b0, 4'd0, '0, rd);
    check("R2 dir read", rd, m_dir);
    check("R3 input pins low", pad_out, m_lat & m_dir);
    check("R2 oe mix", pad_oe, m_dir);
    for (int a = 3; a < 16; a++) begin
      access(1'b0, 4'(a), '0, rd);
      check("R8 read zero", rd, 16'h0);
    end
    access(1'b1, 4'd9, 16'hFFFF, rd);
    access(1'b1, 4'd1, 16'hFFFF, rd);
    access(1'b0, 4'd2, '0, rd);
    check("R8 unused write ignored", rd, m_lat);
    check("R7 write ignored", pad_oe, m_dir);
    // sync latency: pad changes at negedge, captured at next posedge,
    // second flop at following posedge, rdata registered at a third posedge
    pad_in = 16'hC3A5;
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_addr = 4'd1;
    @(negedge clk);
    check("R7 too early", bus_rdata, 16'h0000);
    @(negedge clk);
    bus_stb = 1'b0;
    check("R7 synced level", bus_rdata, 16'hC3A5);
    @(negedge clk);
    check("R9 rdata idle zero", bus_rdata, 16'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", pad_oe | pad_out, 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule